// File: doc/BRIEF.md
# Memory Test Traffic Generator and Checker

This block exercises a simple synchronous memory port with a continuous stream of write and read transactions and checks every word that comes back. Before a run the configuration inputs give the number of addresses to sweep, the source of the data words and the kind of traffic. A start pulse latches that configuration and begins a run. The run repeats its passes over the address range until a stop pulse ends it. Each pass issues one transaction per clock, from address 0 upward.

Three data sources are available: a 31-bit pseudo-random shift register, a 16-entry pattern table, and a value computed from the address plus a programmable offset. A read pass regenerates the same sequence that the matching write pass produced and compares the read data against it.

Two error counters are kept: one for detected mismatches and one for deliberately injected faults. A clear input zeroes both. An injection request corrupts exactly one word of the running stream. Byte counters for issued writes and reads, and their sum, let software derive throughput over a run.

Top module: `memtest_engine`

## Requirements
- R1: At start the address count is clamped to the range 2 to MAX_ADDRS (default 524,288). Each pass then issues one transaction per cycle on addresses 0, 1, … N−1 in ascending order.
- R2: The traffic mode codes are as follows. Code 2 runs only write passes. Code 1 runs only read passes. Code 0 alternates a write pass and a read pass, starting with a write. Code 3 behaves as code 0. Write and read enables are never active together.
- R3: Source code 0 is pseudo-random. A 31-bit register is loaded with PRBS_SEED at the start of every pass. The word for a transaction has bit i equal to register bit (i mod 31). After each transaction the register shifts left, and bit 30 XOR bit 27 enters at bit 0.
- R4: Source code 1 is the pattern table. The word is the byte {~k, k} repeated across the word, where k is the low four address bits.
- R5: Source codes 2 and 3 produce the address plus the offset that was latched at start.
- R6: Read data is expected on mem_rdata in the cycle after mem_re. The detected-error counter rises by one for each returned word that differs from the regenerated expected word.
- R7: While a write pass runs, an accepted injection inverts bit 0 of the next written word. The inserted-error counter rises by one when that word is issued, so the following read pass in code 0 detects exactly one error.
- R8: In read-only mode an accepted injection inverts bit 0 of the next expected word. This gives exactly one detected error and one inserted error.
- R9: An injection request made while no run is active is ignored. Neither counter changes, and no later word is corrupted.
- R10: A clear pulse sets both error counters to zero on the next cycle. It takes priority over a simultaneous increment.
- R11: bytes_written and bytes_read each rise by DATA_W/8 for each issued write or read. Both are zeroed when a run starts. bytes_total equals their sum.
- R12: A start pulse is accepted only while idle, and the configuration is latched only at that moment. A stop pulse returns the block to idle on the next cycle and wins over a start pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run with the current configuration |
| stop | input | 1 | End the running test |
| cfg_addr_count | input | AW+1 | Requested number of addresses per pass |
| cfg_mode | input | 2 | Traffic mode code |
| cfg_src | input | 2 | Data source code |
| cfg_offset | input | DATA_W | Offset for the arithmetic source |
| err_inject | input | 1 | Request a single-word fault |
| err_clear | input | 1 | Zero both error counters |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after mem_re |
| busy | output | 1 | A run is in progress |
| err_detected | output | ERR_W | Mismatching read words |
| err_inserted | output | ERR_W | Faults actually injected |
| bytes_written | output | BYTE_W | Bytes written in this run |
| bytes_read | output | BYTE_W | Bytes read in this run |
| bytes_total | output | BYTE_W | Sum of the two byte counters |

## Verification
A wrong address counter or pass sequencer shows on mem_addr, mem_we and mem_re in the very cycle it goes wrong. A generator that loses step shows on mem_wdata at once in write passes. In read passes the same fault appears as a burst of detected errors two cycles after the affected reads. A broken injection path shows as an inserted count that differs from the number of accepted requests. It can also show as a detected count that is off by one once the next read pass ends. Byte-counter faults are visible only as a total that differs from the transactions observed, which is checked after every run.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [1:0] {
    MODE_WR_RD  = 2'd0,
    MODE_RD     = 2'd1,
    MODE_WR     = 2'd2,
    MODE_ALT    = 2'd3
  } mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } seq_state_t;

  localparam logic [1:0] SRC_PRBS  = 2'd0;
  localparam logic [1:0] SRC_TABLE = 2'd1;

  localparam int PRBS_LEN = 31;

  function automatic logic [PRBS_LEN-1:0] prbs_step(input logic [PRBS_LEN-1:0] s);
    return {s[PRBS_LEN-2:0], s[30] ^ s[27]};
  endfunction

endpackage

// File: rtl/memtest_seq.sv
module memtest_seq
  import memtest_pkg::*;
#(
  parameter int AW        = 19,
  parameter int CW        = 20,
  parameter int DATA_W    = 32,
  parameter int MAX_ADDRS = 524288
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [CW-1:0]     cfg_count,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_src,
  input  logic [DATA_W-1:0] cfg_offset,
  output seq_state_t        state,
  output logic [AW-1:0]     addr,
  output mode_t             mode,
  output logic [1:0]        src,
  output logic [DATA_W-1:0] offset,
  output logic              run_load,
  output logic              reseed
);

  localparam logic [CW-1:0] LIM_MAX = CW'(MAX_ADDRS);
  localparam logic [CW-1:0] LIM_MIN = CW'(2);

  seq_state_t        st_q, st_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [CW-1:0]     lim_q, lim_clamped;
  mode_t             mode_q;
  logic [1:0]        src_q;
  logic [DATA_W-1:0] off_q;
  logic              last_addr;
  logic              load;

  always_comb begin
    if (cfg_count < LIM_MIN)      lim_clamped = LIM_MIN;
    else if (cfg_count > LIM_MAX) lim_clamped = LIM_MAX;
    else                          lim_clamped = cfg_count;
  end

  assign last_addr = ({1'b0, addr_q} == (lim_q - CW'(1)));

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    load   = 1'b0;
    reseed = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start && !stop) begin
          load   = 1'b1;
          reseed = 1'b1;
          addr_d = '0;
          st_d   = (mode_t'(cfg_mode) == MODE_RD) ? ST_READ : ST_WRITE;
        end
      end
      ST_WRITE, ST_READ: begin
        if (stop) begin
          st_d = ST_IDLE;
        end else if (last_addr) begin
          addr_d = '0;
          reseed = 1'b1;
          if (st_q == ST_WRITE) st_d = (mode_q == MODE_WR) ? ST_WRITE : ST_READ;
          else                  st_d = (mode_q == MODE_RD) ? ST_READ : ST_WRITE;
        end else begin
          addr_d = addr_q + AW'(1);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= LIM_MIN;
      mode_q <= MODE_WR_RD;
      src_q  <= SRC_PRBS;
      off_q  <= '0;
    end else if (load) begin
      lim_q  <= lim_clamped;
      mode_q <= mode_t'(cfg_mode);
      src_q  <= cfg_src;
      off_q  <= cfg_offset;
    end
  end

  assign state    = st_q;
  assign addr     = addr_q;
  assign mode     = mode_q;
  assign src      = src_q;
  assign offset   = off_q;
  assign run_load = load;

endmodule

// File: rtl/memtest_patgen.sv
module memtest_patgen
  import memtest_pkg::*;
#(
  parameter int              DATA_W    = 32,
  parameter int              AW        = 19,
  parameter logic [30:0]     PRBS_SEED = 31'h1234_5678
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              advance,
  input  logic [1:0]        src,
  input  logic [DATA_W-1:0] offset,
  input  logic [AW-1:0]     addr,
  output logic [DATA_W-1:0] word
);

  localparam int TBL_DEPTH = 16;
  localparam int TBL_AW    = $clog2(TBL_DEPTH);

  logic [PRBS_LEN-1:0] lfsr_q, lfsr_d;
  logic                lfsr_en;
  logic [DATA_W-1:0]   prbs_word;
  logic [DATA_W-1:0]   tbl_word;
  logic [DATA_W-1:0]   arith_word;
  logic [DATA_W-1:0]   tbl [TBL_DEPTH];

  for (genvar k = 0; k < TBL_DEPTH; k++) begin : g_tbl
    assign tbl[k] = {(DATA_W/8){~4'(k), 4'(k)}};
  end

  assign lfsr_en = reseed || advance;
  assign lfsr_d  = reseed ? PRBS_SEED : prbs_step(lfsr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= PRBS_SEED;
    end else if (lfsr_en) begin
      lfsr_q <= lfsr_d;
    end
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      prbs_word[i] = lfsr_q[i % PRBS_LEN];
    end
  end

  assign tbl_word   = tbl[addr[TBL_AW-1:0]];
  assign arith_word = DATA_W'(addr) + offset;

  always_comb begin
    unique case (src)
      SRC_PRBS:  word = prbs_word;
      SRC_TABLE: word = tbl_word;
      default:   word = arith_word;
    endcase
  end

endmodule

// File: rtl/memtest_check.sv
module memtest_check #(
  parameter int DATA_W = 32,
  parameter int ERR_W  = 32,
  parameter int BYTE_W = 48,
  parameter int PEND_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_load,
  input  logic              busy,
  input  logic              wr_issue,
  input  logic              rd_issue,
  input  logic              ro_mode,
  input  logic [DATA_W-1:0] pattern,
  input  logic [DATA_W-1:0] rdata,
  input  logic              inject,
  input  logic              clear,
  output logic [DATA_W-1:0] wdata,
  output logic [ERR_W-1:0]  err_det,
  output logic [ERR_W-1:0]  err_ins,
  output logic [BYTE_W-1:0] bytes_wr,
  output logic [BYTE_W-1:0] bytes_rd
);

  localparam logic [BYTE_W-1:0] BPW = BYTE_W'(DATA_W / 8);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic              accept, apply, pend_full;
  logic              rv_q;
  logic [DATA_W-1:0] exp_now, exp_q;
  logic              mismatch;
  logic [ERR_W-1:0]  det_q, det_d, ins_q, ins_d;
  logic [BYTE_W-1:0] bw_q, bw_d, br_q, br_d;

  assign accept    = inject && busy;
  assign pend_full = &pend_q;
  assign apply     = (pend_q != '0) && (wr_issue || (rd_issue && ro_mode));

  always_comb begin
    pend_d = pend_q;
    if (!busy) begin
      pend_d = '0;
    end else begin
      if (accept && !pend_full) pend_d = pend_d + PEND_W'(1);
      if (apply)                pend_d = pend_d - PEND_W'(1);
    end
  end

  assign wdata   = pattern ^ DATA_W'(apply && wr_issue);
  assign exp_now = pattern ^ DATA_W'(apply && rd_issue);

  assign mismatch = rv_q && (rdata != exp_q);

  always_comb begin
    det_d = det_q;
    ins_d = ins_q;
    if (clear) begin
      det_d = '0;
      ins_d = '0;
    end else begin
      if (mismatch) det_d = det_q + ERR_W'(1);
      if (apply)    ins_d = ins_q + ERR_W'(1);
    end
  end

  always_comb begin
    bw_d = bw_q;
    br_d = br_q;
    if (run_load) begin
      bw_d = '0;
      br_d = '0;
    end else begin
      if (wr_issue) bw_d = bw_q + BPW;
      if (rd_issue) br_d = br_q + BPW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      rv_q   <= 1'b0;
      det_q  <= '0;
      ins_q  <= '0;
      bw_q   <= '0;
      br_q   <= '0;
    end else begin
      pend_q <= pend_d;
      rv_q   <= rd_issue;
      det_q  <= det_d;
      ins_q  <= ins_d;
      bw_q   <= bw_d;
      br_q   <= br_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
    end else if (rd_issue) begin
      exp_q <= exp_now;
    end
  end

  assign err_det  = det_q;
  assign err_ins  = ins_q;
  assign bytes_wr = bw_q;
  assign bytes_rd = br_q;

endmodule

// File: rtl/memtest_engine.sv
module memtest_engine
  import memtest_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          MAX_ADDRS = 524288,
  parameter int          ERR_W     = 32,
  parameter int          BYTE_W    = 48,
  parameter int          PEND_W    = 4,
  parameter logic [30:0] PRBS_SEED = 31'h1234_5678,
  localparam int         AW        = $clog2(MAX_ADDRS),
  localparam int         CW        = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [CW-1:0]     cfg_addr_count,
  input  logic [1:0]        cfg_mode,
  input  logic [1:0]        cfg_src,
  input  logic [DATA_W-1:0] cfg_offset,
  input  logic              err_inject,
  input  logic              err_clear,
  output logic              mem_we,
  output logic              mem_re,
  output logic [AW-1:0]     mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic [ERR_W-1:0]  err_detected,
  output logic [ERR_W-1:0]  err_inserted,
  output logic [BYTE_W-1:0] bytes_written,
  output logic [BYTE_W-1:0] bytes_read,
  output logic [BYTE_W-1:0] bytes_total
);

  seq_state_t        state;
  logic [AW-1:0]     addr;
  mode_t             mode;
  logic [1:0]        src;
  logic [DATA_W-1:0] offset;
  logic              run_load;
  logic              reseed;
  logic              active;
  logic [DATA_W-1:0] pattern;

  memtest_seq #(
    .AW        (AW),
    .CW        (CW),
    .DATA_W    (DATA_W),
    .MAX_ADDRS (MAX_ADDRS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .stop       (stop),
    .cfg_count  (cfg_addr_count),
    .cfg_mode   (cfg_mode),
    .cfg_src    (cfg_src),
    .cfg_offset (cfg_offset),
    .state      (state),
    .addr       (addr),
    .mode       (mode),
    .src        (src),
    .offset     (offset),
    .run_load   (run_load),
    .reseed     (reseed)
  );

  assign active = (state != ST_IDLE);

  memtest_patgen #(
    .DATA_W    (DATA_W),
    .AW        (AW),
    .PRBS_SEED (PRBS_SEED)
  ) u_pat (
    .clk     (clk),
    .rst_n   (rst_n),
    .reseed  (reseed),
    .advance (active),
    .src     (src),
    .offset  (offset),
    .addr    (addr),
    .word    (pattern)
  );

  memtest_check #(
    .DATA_W (DATA_W),
    .ERR_W  (ERR_W),
    .BYTE_W (BYTE_W),
    .PEND_W (PEND_W)
  ) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_load (run_load),
    .busy     (active),
    .wr_issue (state == ST_WRITE),
    .rd_issue (state == ST_READ),
    .ro_mode  (mode == MODE_RD),
    .pattern  (pattern),
    .rdata    (mem_rdata),
    .inject   (err_inject),
    .clear    (err_clear),
    .wdata    (mem_wdata),
    .err_det  (err_detected),
    .err_ins  (err_inserted),
    .bytes_wr (bytes_written),
    .bytes_rd (bytes_read)
  );

  assign mem_we      = (state == ST_WRITE);
  assign mem_re      = (state == ST_READ);
  assign mem_addr    = addr;
  assign busy        = active;
  assign bytes_total = bytes_written + bytes_read;

endmodule

// File: rtl/memtest_engine_sva.sv
module memtest_engine_sva #(
  parameter int AW        = 19,
  parameter int ERR_W     = 32,
  parameter int BYTE_W    = 48,
  parameter int MAX_ADDRS = 524288
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              stop,
  input logic              err_clear,
  input logic              busy,
  input logic              mem_we,
  input logic              mem_re,
  input logic [AW-1:0]     mem_addr,
  input logic [ERR_W-1:0]  err_detected,
  input logic [ERR_W-1:0]  err_inserted,
  input logic [BYTE_W-1:0] bytes_written,
  input logic [BYTE_W-1:0] bytes_read
);

  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re)); // R12

  AST_ADDR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(mem_addr) < MAX_ADDRS)); // R1

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && mem_addr != '0) |-> (mem_addr == AW'($past(mem_addr) + 1'b1))); // R1

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    err_clear |=> (err_detected == '0 && err_inserted == '0)); // R10

  AST_INS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !err_clear) |=> $stable(err_inserted)); // R9

  AST_INS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !err_clear) |=> (err_inserted == $past(err_inserted) ||
                              err_inserted == ERR_W'($past(err_inserted) + 1'b1))); // R7

  AST_BYTES_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop && !busy) |=> (bytes_written == '0 && bytes_read == '0)); // R11

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !busy); // R12

endmodule

bind memtest_engine memtest_engine_sva #(
  .AW        (AW),
  .ERR_W     (ERR_W),
  .BYTE_W    (BYTE_W),
  .MAX_ADDRS (MAX_ADDRS)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .stop          (stop),
  .err_clear     (err_clear),
  .busy          (busy),
  .mem_we        (mem_we),
  .mem_re        (mem_re),
  .mem_addr      (mem_addr),
  .err_detected  (err_detected),
  .err_inserted  (err_inserted),
  .bytes_written (bytes_written),
  .bytes_read    (bytes_read)
);

// File: tb/memtest_engine_bench.sv
`timescale 1ns/1ps
module memtest_engine_bench;

  localparam int          DW   = 32;
  localparam int          MAXA = 64;
  localparam int          AW   = 6;
  localparam int          CW   = 7;
  localparam int          EW   = 16;
  localparam int          BW   = 32;
  localparam logic [30:0] SEED = 31'h1234_5678;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, stop = 1'b0, err_inject = 1'b0, err_clear = 1'b0;
  logic [CW-1:0] cfg_addr_count = '0;
  logic [1:0]    cfg_mode = '0, cfg_src = '0;
  logic [DW-1:0] cfg_offset = '0;
  logic          mem_we, mem_re, busy;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [EW-1:0] err_detected, err_inserted;
  logic [BW-1:0] bytes_written, bytes_read, bytes_total;

  logic [DW-1:0] mem [MAXA];

  int nchk = 0, nfail = 0;
  int det_exp = 0, ins_exp = 0;

  always #2 clk = ~clk;

  memtest_engine #(
    .DATA_W(DW), .MAX_ADDRS(MAXA), .ERR_W(EW), .BYTE_W(BW), .PEND_W(4), .PRBS_SEED(SEED)
  ) u_memtest_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .cfg_addr_count(cfg_addr_count), .cfg_mode(cfg_mode), .cfg_src(cfg_src),
    .cfg_offset(cfg_offset), .err_inject(err_inject), .err_clear(err_clear),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .err_detected(err_detected),
    .err_inserted(err_inserted), .bytes_written(bytes_written),
    .bytes_read(bytes_read), .bytes_total(bytes_total)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  function automatic logic [30:0] lfsr_step(input logic [30:0] s);
    return {s[29:0], s[30] ^ s[27]};
  endfunction

  function automatic logic [31:0] pat(input int src, input int a,
                                      input logic [30:0] s, input logic [31:0] off);
    logic [31:0] w;
    logic [3:0]  k;
    k = 4'(a);
    case (src)
      0: for (int i = 0; i < 32; i++) w[i] = s[i % 31];
      1: w = {4{~k, k}};
      default: w = 32'(a) + off;
    endcase
    return w;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input int mode, input int src, input int count, input logic [31:0] off,
                     input int ncyc, input int inj_at, input bit mid_start, input string req);
    int lim, st, a, errs, nwr, nrd;
    logic [30:0] s;
    logic [31:0] w;
    bit pend;
    lim = (count < 2) ? 2 : ((count > MAXA) ? MAXA : count);
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_src = 2'(src); cfg_addr_count = CW'(count); cfg_offset = off;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    st = (mode == 1) ? 2 : 1; a = 0; s = SEED; pend = 0; errs = 0; nwr = 0; nrd = 0;
    for (int i = 0; i < ncyc; i++) begin
      if (i > 0) @(negedge clk);
      w = pat(src, a, s, off);
      if (busy !== 1'b1) errs++;
      if (st == 1) begin
        if (mem_we !== 1'b1 || mem_re !== 1'b0 || mem_addr !== AW'(a)) errs++;
        if (pend) begin w ^= 32'd1; pend = 0; ins_exp++; end
        if (mem_wdata !== w) errs++;
        nwr++;
      end else begin
        if (mem_re !== 1'b1 || mem_we !== 1'b0 || mem_addr !== AW'(a)) errs++;
        if (pend && mode == 1) begin w ^= 32'd1; pend = 0; ins_exp++; end
        if (mem[a] !== w) det_exp++;
        nrd++;
      end
      if (a == lim - 1) begin
        a = 0; s = SEED;
        if (st == 1) st = (mode == 2) ? 1 : 2;
        else         st = (mode == 1) ? 2 : 1;
      end else begin
        a++; s = lfsr_step(s);
      end
      err_inject = (i == inj_at);
      if (i == inj_at) pend = 1;
      if (mid_start && i == 3) begin
        start = 1'b1; cfg_mode = ~cfg_mode; cfg_src = ~cfg_src;
        cfg_addr_count = CW'(5); cfg_offset = ~cfg_offset;
      end else begin
        start = mid_start && (i == ncyc - 1);
      end
      stop = (i == ncyc - 1);
    end
    @(negedge clk);
    stop = 1'b0; start = 1'b0; err_inject = 1'b0;
    chk("R12", "busy after stop", busy, 0);
    @(negedge clk);
    @(negedge clk);
    chk(req, "stream errors", errs, 0);
    chk("R6", "detected", err_detected, EW'(det_exp));
    chk("R7", "inserted", err_inserted, EW'(ins_exp));
    chk("R11", "bytes written", bytes_written, 4 * nwr);
    chk("R11", "bytes read", bytes_read, 4 * nrd);
    chk("R11", "bytes total", bytes_total, 4 * (nwr + nrd));
  endtask

  task automatic do_clear();
    @(negedge clk);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    det_exp = 0; ins_exp = 0;
    chk("R10", "detected after clear", err_detected, 0);
    chk("R10", "inserted after clear", err_inserted, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] ins_before;
    void'($urandom(32'd20240611));
    for (int i = 0; i < MAXA; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R12", "busy in reset", busy, 0);
    chk("R2", "enables in reset", {mem_we, mem_re}, 0);
    chk("R10", "counters in reset", {err_detected, err_inserted}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed cases
    run(2, 0, 16, 32'h0, 40, -1, 0, "R3");                  // write-only PRBS
    run(0, 0, 10, 32'h0, 60, -1, 0, "R3");                  // write then read PRBS
    run(0, 1, 20, 32'h0, 70, -1, 0, "R4");                  // table source
    run(0, 2, 7, 32'h1000_0000, 50, -1, 0, "R5");          // arithmetic source
    run(3, 3, 9, 32'hFFFF_FFF0, 45, -1, 0, "R5");          // codes 3 act as 0 and 2
    run(0, 0, 1, 32'h0, 12, -1, 0, "R1");                   // low clamp to 2
    run(2, 2, 0, 32'h5, 10, -1, 0, "R1");                   // zero clamps to 2
    run(2, 2, 100, 32'h0, 150, -1, 0, "R1");                // high clamp to MAX_ADDRS
    run(0, 1, 8, 32'h0, 40, 2, 0, "R7");                    // inject in write pass
    chk("R7", "one detected from one injection", err_detected, 1);
    run(2, 1, 20, 32'h0, 25, -1, 0, "R4");                  // restore table words
    det_exp = det_exp;
    run(1, 1, 16, 32'h0, 40, 5, 0, "R8");                   // read-only injection
    chk("R8", "read-only injection detected", err_detected, 2);
    // R9 idle injection ignored
    ins_before = err_inserted;
    @(negedge clk); err_inject = 1'b1;
    @(negedge clk); err_inject = 1'b0;
    @(negedge clk);
    chk("R9", "inserted unchanged when idle", err_inserted, ins_before);
    run(0, 0, 12, 32'h0, 50, -1, 0, "R9");
    chk("R9", "no late corruption", err_detected, 2);
    do_clear();
    run(0, 2, 6, 32'h77, 40, -1, 1, "R12");                 // start ignored while busy
    // constrained random runs
    for (int r = 0; r < 24; r++) begin
      int m, sc, cnt, len, inj;
      m   = int'($urandom % 4);
      sc  = int'($urandom % 4);
      cnt = int'($urandom % 101);
      len = 10 + int'($urandom % 150);
      inj = ($urandom % 2 == 0) ? int'($urandom % (len - 1)) : -1;
      run(m, sc, cnt, $urandom, len, inj, 0, "R2");
      if (r % 8 == 7) do_clear();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule